// File: doc/BRIEF.md
# Two-level global-history branch direction predictor

This block guesses the direction of conditional branches. It keeps a shift register with the outcomes of the most recent resolved branches. It also keeps one table of saturating counters. A prediction request carries a branch address. One cycle later the block returns a taken or not-taken guess, and with it the history value that was in use when the request was accepted. The surrounding pipeline keeps that history value with the branch. When the branch resolves, the pipeline hands it back together with the address and the real outcome. The block then adjusts exactly the counter the guess came from and shifts the outcome into the history.

A mode input selects how history and address are combined into a table index:

- Concatenation mode: the history picks one bank of counters, and the low address bits pick the entry inside that bank.
- XOR mode: the table is treated as one flat array of counters, indexed by the low address bits XORed with the history.

The history length, counter width and number of address bits used are all parameters.

Top module: `gh_bpred`

## Requirements
- R1: After reset the history register holds zero and every counter holds weakly not-taken, which is value 2^(CNT_W-1)-1 (binary 01 for 2-bit counters). A prediction made before any update is therefore not-taken and reports history 0.
- R2: Each update shifts `upd_taken` into history bit 0 and moves older outcomes one place up, dropping the oldest. A prediction reports in `pred_hist` the history as it stood in the cycle of its request.
- R3: With `idx_xor`=0 the counter index is {history, A}, with history in the upper HIST_W bits. A is the PCB address bits starting at bit PC_SH.
- R4: With `idx_xor`=1 the counter index is the HIST_W+PCB address bits starting at bit PC_SH, XORed with the zero-extended history.
- R5: An update adds one to the selected counter when taken and subtracts one when not-taken. A counter at all ones stays there on taken, and a counter at zero stays there on not-taken.
- R6: `pred_taken` is 1 exactly when the most significant bit of the selected counter is 1.
- R7: An update computes its index from `upd_pc`, the returned `upd_hist` and the current mode. The live history register plays no part in that index.
- R8: When a prediction and an update arrive in the same cycle, the prediction sees the counters and the history from before that update.
- R9: `pred_vld` is 1 in the cycle after a cycle with `pred_req`=1, and 0 in the cycle after a cycle without a request. `pred_taken` and `pred_hist` are valid while `pred_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_xor | input | 1 | Index mode: 0 concatenation, 1 XOR |
| pred_req | input | 1 | Prediction request |
| pred_pc | input | PC_W | Branch address for the prediction |
| upd_req | input | 1 | Update request for a resolved branch |
| upd_pc | input | PC_W | Branch address of the resolved branch |
| upd_hist | input | HIST_W | History snapshot returned with the branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| pred_vld | output | 1 | Prediction result valid |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History used for this prediction |

## Verification
A prediction result is due one clock after its request, because both the counter read and the history capture are registered. An update takes effect at the same edge it is sampled, so its counter and history change are first visible to a request issued in the next cycle. The bench drives inputs on the falling edge. One nanosecond after each rising edge it advances a behavioural model in the order the requirements fix: the prediction is resolved against the old state, and only then is the update applied. It then compares `pred_vld` on every cycle, and `pred_taken` and `pred_hist` on every cycle where a result is due.

// File: rtl/gh_bpred_pkg.sv
`timescale 1ns/1ps
package gh_bpred_pkg;
  // Index formation choice for the counter table
  typedef enum logic {
    IDX_CONCAT = 1'b0,
    IDX_XOR    = 1'b1
  } idx_mode_e;
endpackage

// File: rtl/gh_index.sv
`timescale 1ns/1ps
module gh_index #(
  parameter int HIST_W = 2,
  parameter int PCB    = 4,
  localparam int IDX_W = HIST_W + PCB
) (
  input  gh_bpred_pkg::idx_mode_e mode,
  input  logic [IDX_W-1:0]        pc_bits,
  input  logic [HIST_W-1:0]       hist,
  output logic [IDX_W-1:0]        idx
);
  import gh_bpred_pkg::*;

  function automatic logic [IDX_W-1:0] form_idx(
    input idx_mode_e m, input logic [IDX_W-1:0] a, input logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] r;
    if (m == IDX_XOR) r = a ^ {{PCB{1'b0}}, h};
    else              r = {h, a[PCB-1:0]};
    return r;
  endfunction

  assign idx = form_idx(mode, pc_bits, hist);

  always_comb begin
    if (mode == IDX_XOR) begin
      // R4: undoing the address bits leaves the history
      a_r4_xor_index: assert ((idx ^ pc_bits) == IDX_W'(hist));
    end else begin
      // R3: bank from history, entry from address
      a_r3_concat_index: assert (idx[IDX_W-1:PCB] == hist && idx[PCB-1:0] == pc_bits[PCB-1:0]);
    end
  end
endmodule

// File: rtl/gh_hist_reg.sv
`timescale 1ns/1ps
module gh_hist_reg #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  assign hist = hist_q;

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= bit_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n)        hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
      end
      // R2: older outcomes move up by one place
      a_r2_age_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
    end
  endgenerate

  // R2: newest outcome lands in bit 0
  a_r2_newest_bit: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(bit_in));
  // R2: no update, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/gh_ctr_table.sv
`timescale 1ns/1ps
module gh_ctr_table #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 2,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam logic [CNT_W-1:0] CTR_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CTR_INIT = CTR_MAX >> 1;

  logic [CNT_W-1:0] ctr_q [DEPTH];
  logic [CNT_W-1:0] rd_q;
  logic [CNT_W-1:0] wr_old;
  logic [CNT_W-1:0] wr_new;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c, input logic up);
    logic [CNT_W-1:0] r;
    r = c;
    if (up && c != CTR_MAX)       r = c + 1'b1;
    else if (!up && c != '0)      r = c - 1'b1;
    return r;
  endfunction

  assign wr_old = ctr_q[wr_idx];
  assign wr_new = sat_step(wr_old, wr_taken);
  assign rd_ctr = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_INIT;
      rd_q <= CTR_INIT;
    end else begin
      if (wr_en) ctr_q[wr_idx] <= wr_new;
      if (rd_en) rd_q <= ctr_q[rd_idx];
    end
  end

  // R5: saturation at the top
  a_r5_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old == CTR_MAX) |=> ctr_q[$past(wr_idx)] == CTR_MAX);
  // R5: saturation at the bottom
  a_r5_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old == '0) |=> ctr_q[$past(wr_idx)] == '0);
  // R5: single step up away from the top
  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old != CTR_MAX) |=>
      ctr_q[$past(wr_idx)] == $past(wr_old) + 1'b1);
  // R8: the read returns the value held before any same-cycle write
  a_r8_old_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_q == $past(ctr_q[rd_idx]));
endmodule

// File: rtl/gh_bpred.sv
`timescale 1ns/1ps
module gh_bpred #(
  parameter int PC_W   = 32,
  parameter int PC_SH  = 2,
  parameter int HIST_W = 2,
  parameter int PCB    = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_xor,
  input  logic              pred_req,
  input  logic [PC_W-1:0]   pred_pc,
  input  logic              upd_req,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken,
  output logic              pred_vld,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist
);
  import gh_bpred_pkg::*;

  localparam int IDX_W = HIST_W + PCB;

  idx_mode_e         mode;
  logic [HIST_W-1:0] live_hist;
  logic [IDX_W-1:0]  pred_bits, upd_bits;
  logic [IDX_W-1:0]  pred_idx, upd_idx;
  logic [CNT_W-1:0]  sel_ctr;
  logic              ev_pred, ev_upd;
  logic              vld_q;
  logic [HIST_W-1:0] hist_snap_q;
  logic              unused_bits;

  assign mode      = idx_mode_e'(idx_xor);
  assign ev_pred   = pred_req;
  assign ev_upd    = upd_req;
  assign pred_bits = pred_pc[PC_SH +: IDX_W];
  assign upd_bits  = upd_pc[PC_SH +: IDX_W];
  assign unused_bits = ^{pred_pc, upd_pc, sel_ctr};

  gh_index #(.HIST_W(HIST_W), .PCB(PCB)) u_pred_index (
    .mode(mode), .pc_bits(pred_bits), .hist(live_hist), .idx(pred_idx));

  gh_index #(.HIST_W(HIST_W), .PCB(PCB)) u_upd_index (
    .mode(mode), .pc_bits(upd_bits), .hist(upd_hist), .idx(upd_idx));

  gh_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(ev_upd), .bit_in(upd_taken), .hist(live_hist));

  gh_ctr_table #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_en(ev_pred), .rd_idx(pred_idx), .rd_ctr(sel_ctr),
    .wr_en(ev_upd), .wr_idx(upd_idx), .wr_taken(upd_taken));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q       <= 1'b0;
      hist_snap_q <= '0;
    end else begin
      vld_q <= ev_pred;
      if (ev_pred) hist_snap_q <= live_hist;
    end
  end

  assign pred_vld   = vld_q;
  assign pred_taken = sel_ctr[CNT_W-1];
  assign pred_hist  = hist_snap_q;

  // R9: a result follows each request by one cycle
  a_r9_result_due: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pred |=> pred_vld);
  // R9: no result without a request
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_pred |=> !pred_vld);
  // R2 / R8: reported history is the one before a same-cycle update
  a_r8_hist_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pred |=> pred_hist == $past(live_hist));
endmodule

// File: tb/gh_bpred_tb.sv
`timescale 1ns/1ps
module gh_bpred_tb;
  localparam int PC_W = 32, PC_SH = 2, HIST_W = 2, PCB = 4, CNT_W = 2;
  localparam int IW     = HIST_W + PCB;
  localparam int NENT   = 2 ** IW;
  localparam int HMOD   = 2 ** HIST_W;
  localparam int CMAX   = 2 ** CNT_W - 1;
  localparam int CHALF  = 2 ** (CNT_W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idx_xor = 1'b0;
  logic pred_req = 1'b0;
  logic [PC_W-1:0] pred_pc = '0;
  logic upd_req = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic [HIST_W-1:0] upd_hist = '0;
  logic upd_taken = 1'b0;
  logic pred_vld, pred_taken;
  logic [HIST_W-1:0] pred_hist;

  always #2.5 clk = ~clk;

  gh_bpred #(.PC_W(PC_W), .PC_SH(PC_SH), .HIST_W(HIST_W), .PCB(PCB), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .idx_xor(idx_xor),
    .pred_req(pred_req), .pred_pc(pred_pc),
    .upd_req(upd_req), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken),
    .pred_vld(pred_vld), .pred_taken(pred_taken), .pred_hist(pred_hist));

  int n_total = 0;
  int n_fail  = 0;
  int model_ctr [NENT];
  int model_hist = 0;
  string cur_req = "R1";
  int q_pc [$];
  int q_h  [$];
  int last_hist = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Table position computed from the requirement text (R3, R4)
  function automatic int where(input bit xm, input int pc, input int h);
    int a;
    a = (pc >>> PC_SH) % NENT;
    if (xm) return a ^ h;
    return h * (2 ** PCB) + (a % (2 ** PCB));
  endfunction

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:8]);
  endfunction

  // One clock: drive on the falling edge, model then compare just after the rising edge
  task automatic cyc(input bit p, input int ppc, input bit u, input int upc, input int uh, input bit ut);
    bit exp_v, exp_t;
    int exp_h, k;
    @(negedge clk);
    pred_req = p; pred_pc = ppc; upd_req = u; upd_pc = upc;
    upd_hist = uh[HIST_W-1:0]; upd_taken = ut;
    @(posedge clk);
    #1;
    exp_v = p; exp_t = 1'b0; exp_h = model_hist;
    if (p) begin
      k = where(idx_xor, ppc, model_hist);
      exp_t = (model_ctr[k] >= CHALF);
    end
    if (u) begin
      k = where(idx_xor, upc, uh);
      if (ut && model_ctr[k] < CMAX) model_ctr[k]++;
      else if (!ut && model_ctr[k] > 0) model_ctr[k]--;
      model_hist = ((model_hist * 2) + int'(ut)) % HMOD;
    end
    chk(pred_vld == exp_v, "R9", "pred_vld", int'(pred_vld), int'(exp_v));
    if (exp_v) begin
      chk(pred_taken == exp_t, cur_req, "pred_taken", int'(pred_taken), int'(exp_t));
      chk(int'(pred_hist) == exp_h, cur_req, "pred_hist", int'(pred_hist), exp_h);
      last_hist = exp_h;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NENT; i++) model_ctr[i] = CHALF - 1;
    repeat (3) @(posedge clk);
    #1;
    chk(pred_vld == 1'b0, "R1", "pred_vld in reset", int'(pred_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every concat-mode entry for history 0 starts weakly not-taken
    cur_req = "R1";
    for (int a = 0; a < 2 ** PCB; a++) cyc(1, a * 4, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);

    // R8: predict and update the same entry in the same cycle
    cur_req = "R8";
    cyc(1, 32'h8, 1, 32'h8, 0, 1);
    cyc(1, 32'h8, 0, 0, 0, 0);

    // R2: history sequence seen through pred_hist
    cur_req = "R2";
    cyc(1, 32'h0, 1, 32'h100, 1, 0);
    cyc(1, 32'h0, 1, 32'h104, 2, 1);
    cyc(1, 32'h0, 1, 32'h108, 1, 1);
    cyc(1, 32'h0, 0, 0, 0, 0);
    chk(int'(pred_hist) == 3, "R2", "history after 0,1,1", int'(pred_hist), 3);

    // R5/R6: drive one entry to the top and back, beyond both ends
    cur_req = "R5";
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 32'h14, 0, 1);
    cyc(1, 32'h14 | 32'h0, 0, 0, 0, 0);
    cyc(0, 0, 1, 32'h14, 0, 0);
    cur_req = "R6";
    for (int h = 0; h < HMOD; h++) begin
      cyc(0, 0, 1, 32'h3C, h, h[0]);
    end
    cur_req = "R5";
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 32'h14, 0, 0);
    cyc(0, 0, 1, 32'h14, 0, 1);
    cyc(0, 0, 1, 32'h18, 0, 0);
    cyc(0, 0, 1, 32'h18, 0, 0);
    cyc(1, 32'h14, 0, 0, 0, 0);
    chk(pred_taken == 1'b0, "R5", "counter at 1 after floor then one taken", int'(pred_taken), 0);

    // R7: train an entry through a stale snapshot while live history differs
    cur_req = "R7";
    cyc(0, 0, 1, 32'h20, 3, 1);
    cyc(0, 0, 1, 32'h20, 3, 1);
    cyc(0, 0, 1, 32'h20, 0, 1);
    cyc(0, 0, 1, 32'h20, 0, 1);
    cyc(1, 32'h24, 0, 0, 0, 0);
    cyc(0, 0, 1, 32'h30, 0, 1);
    cyc(0, 0, 1, 32'h30, 0, 1);
    cyc(1, 32'h20, 0, 0, 0, 0);
    chk(pred_taken == 1'b1, "R7", "snapshot-trained entry", int'(pred_taken), 1);

    // R3 then R4: mixed traffic, updates return the snapshot of an earlier prediction
    for (int m = 0; m < 2; m++) begin
      idx_xor = m[0];
      cur_req = (m == 0) ? "R3" : "R4";
      for (int i = 0; i < 400; i++) begin
        bit p, u, t;
        int pc, upc, uh;
        p = (rnd() % 3) != 0;
        pc = (rnd() % 24) * 4;
        u = (q_pc.size() > 0) && ((rnd() % 2) == 0 || q_pc.size() > 3);
        t = ((pc / 4) % 3) != 0 ? 1'b1 : ((rnd() % 4) == 0);
        upc = 0; uh = 0;
        if (u) begin
          upc = q_pc.pop_front();
          uh  = q_h.pop_front();
        end
        cyc(p, pc, u, upc, uh, u ? t : 1'b0);
        if (p) begin
          q_pc.push_back(pc);
          q_h.push_back(last_hist);
        end
      end
      while (q_pc.size() > 0) cyc(0, 0, 1, q_pc.pop_front(), q_h.pop_front(), 1);
    end
    cyc(0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule